// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns a decoded operand specifier into the address an 8/16-bit CPU core uses to reach its operand. Decode supplies a mode code, a byte/word size flag, the value of the selected 16-bit base register, the address of the next instruction, and the short (8-bit) and long (16-bit) constant fields of the instruction. The unit returns the effective address. It also flags whether the operand is a memory location, an immediate constant or a register, and it returns the value to write back to the base register when the mode changes that register. A misalignment error flags word accesses at odd addresses.

Most modes are resolved in a single registered step, one cycle after the request is taken. The memory-indirect mode takes two steps. The unit first raises a read request for the pointer word in the top 256-byte page and holds a busy signal. It then takes the word returned by memory, which is valid in that same cycle, and presents it as the effective address. A request offered while busy is dropped.

Top module: `ea_gen`

## Requirements
- R1: After reset, and until the first accepted request, valid_o, mem_o, imm_o, wb_en_o, misalign_o, busy_o and ind_rd_o are low, and ea_o and wb_val_o are zero.
- R2: Register indirect (mode 1) gives ea_o = base_i. Short absolute (mode 5) gives ea_o = {8'hFF, short_i}. Long absolute (mode 6) gives ea_o = long_i. mem_o is high in all three.
- R3: Displacement (mode 2) gives ea_o = base_i + long_i modulo 2^16, with mem_o high.
- R4: Post-increment (mode 3) gives ea_o = base_i, with wb_en_o high and wb_val_o = base_i + 1 for a byte (word_i=0) or base_i + 2 for a word (word_i=1), modulo 2^16.
- R5: Pre-decrement (mode 4) gives ea_o = wb_val_o = base_i - 1 for a byte or base_i - 2 for a word, modulo 2^16, with wb_en_o high.
- R6: misalign_o is raised with the result when word_i=1, ea_o is odd and the mode is 1 to 6. It is also raised for memory indirect (mode 10) whenever short_i is odd. It is never raised otherwise.
- R7: Register direct (mode 0), and every unused code (11 to 15), gives valid_o high with mem_o, imm_o, wb_en_o and misalign_o low, and ea_o zero.
- R8: Short immediate (mode 7) gives ea_o = {8'h00, short_i}. Long immediate (mode 8) gives ea_o = long_i. imm_o is high and mem_o is low in both.
- R9: PC-relative (mode 9) gives ea_o = pc_next_i + sign-extended short_i, modulo 2^16, with mem_o high.
- R10: Memory indirect (mode 10) is handled in two cycles. In the first cycle after acceptance, busy_o and ind_rd_o are high, valid_o is low and ea_o = {8'hFF, short_i}. In the next cycle, valid_o and mem_o are high and ea_o equals the rd_data_i value present during the first cycle.
- R11: start_i is ignored while busy_o is high. No second result follows the indirect result.
- R12: A request accepted at a clock edge (start_i high, busy_o low, mode other than 10) gives valid_o high for exactly the following cycle. valid_o, mem_o, imm_o and wb_en_o are low in any cycle that follows no accepted request and no busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken when busy_o is low |
| mode_i | input | 4 | Addressing mode code |
| word_i | input | 1 | Operand size: 1 word, 0 byte |
| base_i | input | 16 | Selected base register value |
| pc_next_i | input | 16 | Address of the next instruction |
| short_i | input | 8 | Short constant field |
| long_i | input | 16 | Long constant field |
| rd_data_i | input | 16 | Pointer word returned by memory while ind_rd_o is high |
| valid_o | output | 1 | Result valid this cycle |
| ea_o | output | 16 | Effective address or immediate constant |
| mem_o | output | 1 | Operand is in memory at ea_o |
| imm_o | output | 1 | Operand is the constant on ea_o |
| wb_en_o | output | 1 | Base register write-back enable |
| wb_val_o | output | 16 | Base register write-back value |
| misalign_o | output | 1 | Word access at an odd address |
| busy_o | output | 1 | Indirect pointer fetch in progress |
| ind_rd_o | output | 1 | Pointer word read request at ea_o |

## Verification
The assertions assume that memory answers a pointer read in the same cycle that ind_rd_o is raised. They also assume that the request fields stay stable only at the edge where start_i is sampled, so each property compares outputs with inputs taken at that edge through $past. The bench drives every input on the falling clock edge and models memory in the same way, presenting rd_data_i during the busy cycle. Random requests cover all sixteen mode codes, both sizes, and base values near 0 and 0xFFFF. Directed cases add wrap-around, odd addresses and a request made while busy.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [3:0] {
    MD_REG_DIR  = 4'd0,
    MD_REG_IND  = 4'd1,
    MD_DISP     = 4'd2,
    MD_POST_INC = 4'd3,
    MD_PRE_DEC  = 4'd4,
    MD_ABS_S    = 4'd5,
    MD_ABS_L    = 4'd6,
    MD_IMM_S    = 4'd7,
    MD_IMM_L    = 4'd8,
    MD_PC_REL   = 4'd9,
    MD_MEM_IND  = 4'd10
  } ea_mode_e;

  localparam int unsigned MODE_W = 4;
endpackage

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned SHORT_W = 8
) (
  input  logic [MODE_W-1:0]  mode_i,
  input  logic               word_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [ADDR_W-1:0]  pc_next_i,
  input  logic [SHORT_W-1:0] short_i,
  input  logic [ADDR_W-1:0]  long_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               mem_o,
  output logic               imm_o,
  output logic               wb_en_o,
  output logic [ADDR_W-1:0]  wb_val_o,
  output logic               mis_o,
  output logic               ind_o
);
  localparam int unsigned EXT_W = ADDR_W - SHORT_W;

  logic [ADDR_W-1:0] step, top_page, zext, sext, dec_val;
  logic              align_chk;

  assign step     = word_i ? ADDR_W'(2) : ADDR_W'(1);
  assign top_page = {{EXT_W{1'b1}}, short_i};
  assign zext     = {{EXT_W{1'b0}}, short_i};
  assign sext     = {{EXT_W{short_i[SHORT_W-1]}}, short_i};
  assign dec_val  = base_i - step;

  always_comb begin
    addr_o    = '0;
    mem_o     = 1'b0;
    imm_o     = 1'b0;
    wb_en_o   = 1'b0;
    wb_val_o  = '0;
    ind_o     = 1'b0;
    align_chk = 1'b0;
    case (mode_i)
      MD_REG_IND: begin
        addr_o = base_i; mem_o = 1'b1; align_chk = 1'b1;
      end
      MD_DISP: begin
        addr_o = base_i + long_i; mem_o = 1'b1; align_chk = 1'b1;
      end
      MD_POST_INC: begin
        addr_o = base_i; mem_o = 1'b1; align_chk = 1'b1;
        wb_en_o = 1'b1; wb_val_o = base_i + step;
      end
      MD_PRE_DEC: begin
        addr_o = dec_val; mem_o = 1'b1; align_chk = 1'b1;
        wb_en_o = 1'b1; wb_val_o = dec_val;
      end
      MD_ABS_S: begin
        addr_o = top_page; mem_o = 1'b1; align_chk = 1'b1;
      end
      MD_ABS_L: begin
        addr_o = long_i; mem_o = 1'b1; align_chk = 1'b1;
      end
      MD_IMM_S: begin
        addr_o = zext; imm_o = 1'b1;
      end
      MD_IMM_L: begin
        addr_o = long_i; imm_o = 1'b1;
      end
      MD_PC_REL: begin
        addr_o = pc_next_i + sext; mem_o = 1'b1;
      end
      MD_MEM_IND: begin
        addr_o = top_page; ind_o = 1'b1;
      end
      default: ;
    endcase
  end

  // pointer fetch is always a word read
  assign mis_o = addr_o[0] & ((align_chk & word_i) | ind_o);
endmodule

// File: rtl/ea_ind_seq.sv
module ea_ind_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  output logic busy_o
);
  typedef enum logic {ST_IDLE, ST_FETCH} ind_st_e;
  ind_st_e st_q, st_d;

  always_comb begin
    st_d = ST_IDLE;
    if (st_q == ST_IDLE && launch_i) st_d = ST_FETCH;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign busy_o = (st_q == ST_FETCH);
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned SHORT_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [3:0]         mode_i,
  input  logic               word_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [ADDR_W-1:0]  pc_next_i,
  input  logic [SHORT_W-1:0] short_i,
  input  logic [ADDR_W-1:0]  long_i,
  input  logic [ADDR_W-1:0]  rd_data_i,
  output logic               valid_o,
  output logic [ADDR_W-1:0]  ea_o,
  output logic               mem_o,
  output logic               imm_o,
  output logic               wb_en_o,
  output logic [ADDR_W-1:0]  wb_val_o,
  output logic               misalign_o,
  output logic               busy_o,
  output logic               ind_rd_o
);
  logic [ADDR_W-1:0] c_addr, c_wb;
  logic c_mem, c_imm, c_wb_en, c_mis, c_ind;
  logic busy, accept;
  logic valid_q, mem_q, imm_q, wb_en_q, mis_q, ptr_mis_q;
  logic [ADDR_W-1:0] ea_q, wb_q;

  ea_calc #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_calc (
    .mode_i   (mode_i),
    .word_i   (word_i),
    .base_i   (base_i),
    .pc_next_i(pc_next_i),
    .short_i  (short_i),
    .long_i   (long_i),
    .addr_o   (c_addr),
    .mem_o    (c_mem),
    .imm_o    (c_imm),
    .wb_en_o  (c_wb_en),
    .wb_val_o (c_wb),
    .mis_o    (c_mis),
    .ind_o    (c_ind)
  );

  assign accept = start_i & ~busy;

  ea_ind_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(accept & c_ind),
    .busy_o  (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      mem_q     <= 1'b0;
      imm_q     <= 1'b0;
      wb_en_q   <= 1'b0;
      mis_q     <= 1'b0;
      ptr_mis_q <= 1'b0;
      ea_q      <= '0;
      wb_q      <= '0;
    end else begin
      valid_q <= 1'b0;
      mem_q   <= 1'b0;
      imm_q   <= 1'b0;
      wb_en_q <= 1'b0;
      mis_q   <= 1'b0;
      if (busy) begin
        valid_q <= 1'b1;
        mem_q   <= 1'b1;
        mis_q   <= ptr_mis_q;
        ea_q    <= rd_data_i;
      end else if (accept) begin
        ea_q <= c_addr;
        if (c_ind) begin
          ptr_mis_q <= c_mis;
        end else begin
          valid_q <= 1'b1;
          mem_q   <= c_mem;
          imm_q   <= c_imm;
          wb_en_q <= c_wb_en;
          mis_q   <= c_mis;
          if (c_wb_en) wb_q <= c_wb;
        end
      end
    end
  end

  assign valid_o    = valid_q;
  assign ea_o       = ea_q;
  assign mem_o      = mem_q;
  assign imm_o      = imm_q;
  assign wb_en_o    = wb_en_q;
  assign wb_val_o   = wb_q;
  assign misalign_o = mis_q;
  assign busy_o     = busy;
  assign ind_rd_o   = busy;
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [3:0]        mode_i,
  input logic              word_i,
  input logic [ADDR_W-1:0] base_i,
  input logic              valid_o,
  input logic [ADDR_W-1:0] ea_o,
  input logic              mem_o,
  input logic              imm_o,
  input logic              wb_en_o,
  input logic [ADDR_W-1:0] wb_val_o,
  input logic              misalign_o,
  input logic              busy_o,
  input logic              ind_rd_o
);
  assert_post_inc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && mode_i == 4'd3) |=>
      (valid_o && wb_en_o && ea_o == $past(base_i) &&
       wb_val_o == $past(base_i) + ($past(word_i) ? ADDR_W'(2) : ADDR_W'(1))));

  assert_pre_dec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && mode_i == 4'd4) |=>
      (wb_en_o && ea_o == wb_val_o &&
       ea_o == $past(base_i) - ($past(word_i) ? ADDR_W'(2) : ADDR_W'(1))));

  assert_mis_with_result_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (valid_o && mem_o));

  assert_imm_no_mem_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imm_o |-> (valid_o && !mem_o && !wb_en_o));

  assert_ind_fetch_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ind_rd_o |-> (busy_o && !valid_o));

  assert_ind_result_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ind_rd_o |=> (valid_o && mem_o && !busy_o));

  assert_busy_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o);

  assert_one_cycle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && mode_i != 4'd10) |=> valid_o);

  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !busy_o) |=> (!valid_o && !wb_en_o && !imm_o));
endmodule

bind ea_gen ea_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .mode_i    (mode_i),
  .word_i    (word_i),
  .base_i    (base_i),
  .valid_o   (valid_o),
  .ea_o      (ea_o),
  .mem_o     (mem_o),
  .imm_o     (imm_o),
  .wb_en_o   (wb_en_o),
  .wb_val_o  (wb_val_o),
  .misalign_o(misalign_o),
  .busy_o    (busy_o),
  .ind_rd_o  (ind_rd_o)
);

// File: tb/ea_gen_tb_top.sv
module ea_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  mode_i = '0;
  logic        word_i = 1'b0;
  logic [15:0] base_i = '0, pc_next_i = '0, long_i = '0, rd_data_i = '0;
  logic [7:0]  short_i = '0;
  logic        valid_o, mem_o, imm_o, wb_en_o, misalign_o, busy_o, ind_rd_o;
  logic [15:0] ea_o, wb_val_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;

  ea_gen dut_i (.*);

  typedef struct packed {
    logic [15:0] ea;
    logic [15:0] wb;
    logic mem, imm, wb_en, mis;
  } exp_t;

  function automatic exp_t model(input logic [3:0] m, input logic w,
      input logic [15:0] b, input logic [15:0] pc, input logic [7:0] s,
      input logic [15:0] l, input logic [15:0] rd);
    exp_t e;
    logic [15:0] st;
    st = w ? 16'd2 : 16'd1;
    e = '0;
    case (m)
      4'd1:  begin e.ea = b; e.mem = 1; end
      4'd2:  begin e.ea = b + l; e.mem = 1; end
      4'd3:  begin e.ea = b; e.wb = b + st; e.wb_en = 1; e.mem = 1; end
      4'd4:  begin e.ea = b - st; e.wb = b - st; e.wb_en = 1; e.mem = 1; end
      4'd5:  begin e.ea = {8'hFF, s}; e.mem = 1; end
      4'd6:  begin e.ea = l; e.mem = 1; end
      4'd7:  begin e.ea = {8'h00, s}; e.imm = 1; end
      4'd8:  begin e.ea = l; e.imm = 1; end
      4'd9:  begin e.ea = pc + {{8{s[7]}}, s}; e.mem = 1; end
      4'd10: begin e.ea = rd; e.mem = 1; e.mis = s[0]; end
      default: ;
    endcase
    if (m >= 4'd1 && m <= 4'd6) e.mis = w & e.ea[0];
    return e;
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // issue one request, check all outputs; wb_val only when written
  task automatic run_op(input string req, input logic [3:0] m, input logic w,
      input logic [15:0] b, input logic [15:0] pc, input logic [7:0] s,
      input logic [15:0] l, input logic [15:0] rd);
    exp_t e;
    e = model(m, w, b, pc, s, l, rd);
    @(negedge clk_i);
    start_i = 1; mode_i = m; word_i = w; base_i = b; pc_next_i = pc;
    short_i = s; long_i = l;
    @(negedge clk_i);
    start_i = 0;
    if (m == 4'd10) begin
      chk(req, "busy", {15'd0, busy_o}, 16'd1);
      chk(req, "ind_rd", {15'd0, ind_rd_o}, 16'd1);
      chk(req, "valid_in_fetch", {15'd0, valid_o}, 16'd0);
      chk(req, "ptr_addr", ea_o, {8'hFF, s});
      rd_data_i = rd;
      @(negedge clk_i);
      rd_data_i = 16'hDEAD;
    end
    chk(req, "valid", {15'd0, valid_o}, 16'd1);
    chk(req, "ea", ea_o, e.ea);
    chk(req, "mem", {15'd0, mem_o}, {15'd0, e.mem});
    chk(req, "imm", {15'd0, imm_o}, {15'd0, e.imm});
    chk(req, "wb_en", {15'd0, wb_en_o}, {15'd0, e.wb_en});
    chk(req, "misalign", {15'd0, misalign_o}, {15'd0, e.mis});
    if (e.wb_en) chk(req, "wb_val", wb_val_o, e.wb);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", "valid", {15'd0, valid_o}, 16'd0);
    chk("R1", "flags", {9'd0, mem_o, imm_o, wb_en_o, misalign_o, busy_o, ind_rd_o, 1'b0}, 16'd0);
    chk("R1", "ea", ea_o, 16'd0);
    chk("R1", "wb_val", wb_val_o, 16'd0);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1", "valid_after_release", {15'd0, valid_o}, 16'd0);

    run_op("R7", 4'd0, 1, 16'h1234, 16'h0, 8'h11, 16'h2222, 16'h0);
    run_op("R7", 4'd13, 0, 16'h5555, 16'h0, 8'h33, 16'h4444, 16'h0);
    run_op("R2", 4'd1, 0, 16'h4A31, 16'h0, 8'h00, 16'h0, 16'h0);
    run_op("R2", 4'd5, 0, 16'h0, 16'h0, 8'h7C, 16'h0, 16'h0);
    run_op("R2", 4'd6, 0, 16'h0, 16'h0, 8'h00, 16'h1235, 16'h0);
    run_op("R3", 4'd2, 1, 16'hFFF0, 16'h0, 8'h00, 16'h0020, 16'h0);
    run_op("R4", 4'd3, 0, 16'h0011, 16'h0, 8'h00, 16'h0, 16'h0);
    run_op("R4", 4'd3, 1, 16'hFFFE, 16'h0, 8'h00, 16'h0, 16'h0);
    run_op("R5", 4'd4, 1, 16'h0000, 16'h0, 8'h00, 16'h0, 16'h0);
    run_op("R5", 4'd4, 0, 16'h8000, 16'h0, 8'h00, 16'h0, 16'h0);
    run_op("R6", 4'd2, 1, 16'h1000, 16'h0, 8'h00, 16'h0003, 16'h0);
    run_op("R6", 4'd2, 0, 16'h1000, 16'h0, 8'h00, 16'h0003, 16'h0);
    run_op("R6", 4'd3, 1, 16'h2001, 16'h0, 8'h00, 16'h0, 16'h0);
    run_op("R6", 4'd10, 0, 16'h0, 16'h0, 8'h41, 16'h0, 16'h1234);
    run_op("R6", 4'd9, 1, 16'h0, 16'h1001, 8'h00, 16'h0, 16'h0);
    run_op("R8", 4'd7, 0, 16'h0, 16'h0, 8'hA5, 16'h0, 16'h0);
    run_op("R8", 4'd8, 1, 16'h0, 16'h0, 8'h00, 16'hC3C3, 16'h0);
    run_op("R9", 4'd9, 0, 16'h0, 16'h1000, 8'h80, 16'h0, 16'h0);
    run_op("R9", 4'd9, 0, 16'h0, 16'hFFF0, 8'h7F, 16'h0, 16'h0);
    run_op("R10", 4'd10, 1, 16'h0, 16'h0, 8'h40, 16'h0, 16'hBEEF);

    // R11: request during busy is dropped
    @(negedge clk_i);
    start_i = 1; mode_i = 4'd10; short_i = 8'h20;
    @(negedge clk_i);
    mode_i = 4'd1; base_i = 16'h1234; rd_data_i = 16'h5678;
    @(negedge clk_i);
    start_i = 0;
    chk("R11", "ea_is_pointer", ea_o, 16'h5678);
    @(negedge clk_i);
    chk("R11", "no_extra_result", {15'd0, valid_o}, 16'd0);

    // R12: valid lasts one cycle
    run_op("R12", 4'd1, 0, 16'h0F0F, 16'h0, 8'h00, 16'h0, 16'h0);
    @(negedge clk_i);
    chk("R12", "valid_drops", {15'd0, valid_o}, 16'd0);
    chk("R12", "wb_en_drops", {15'd0, wb_en_o}, 16'd0);

    for (int i = 0; i < 400; i++) begin
      logic [15:0] b;
      b = ($urandom_range(0, 3) == 0) ? (16'hFFFC + 16'($urandom_range(0, 7)))
                                      : 16'($urandom());
      run_op("R12_rand", 4'($urandom_range(0, 15)), 1'($urandom()), b,
             16'($urandom()), 8'($urandom()), 16'($urandom()), 16'($urandom()));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule